// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs the external memory bus of a small microcontroller. The address and the data share the same port pins. An active-low enable strobe (E) separates the address term from the data term. A width-select input chooses between two bus widths. One is a 16-bit data bus that uses two byte lanes, one lane for odd addresses and one for even addresses. The other is an 8-bit data bus on a single lane. A core-side requester pulses a request that carries an address, a direction, a size, an internal-target flag and write data. The block then sequences one bus cycle. It drives the read/write line, the active-low byte-high enable, the address-latch enable (ALE) and E. It also drives the per-lane output enables that set the pin directions. It ends the cycle with a one-cycle done pulse and the read data.

A two-bit processor-mode input selects what the ports do. Value 01 is memory expansion, and the ports become bus pins. Every other value is single-chip operation: the ports pass general I/O values and enables through, and the bus control lines stay idle. A separate enable turns an auxiliary pin into a free-running clock at half the block clock. Accesses to internal memory run the same cycle. They never capture pin data, and when an inhibit input is set they leave E high.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: An accepted request runs an address term (ALE high, one cycle), a hold term (ALE low, address still driven, one cycle) and a data term of DATA_CYC cycles. In the cycle after the data term, done_o is high for exactly one cycle. busy_o is high from the address term until done_o.
- R2: With bus_byte_i low (16-bit bus), the address travels on three ports outside the data term: p0 carries bits 7:0, p1 carries bits 15:8 and p2 carries bits 23:16. In the data term, p1 is the odd-address byte lane and p2 is the even-address byte lane.
- R3: With bus_byte_i high (8-bit bus), p1 carries address bits 15:8 in every term, including the data term. p2 carries all data bytes in the data term.
- R4: rw_o is high for a read and low for a write throughout a cycle, and high while idle.
- R5: bhe_n_o is low during a cycle whose odd byte is transferred: a byte access with A0 = 1, or a 16-bit access on the 16-bit bus. A 16-bit access always places A0 = 0 on the pins.
- R6: During a read data term, no data lane is driven. At the end of the term the pin data is captured into rdata_o. A 16-bit access returns {odd, even}. A byte access returns {8'h00, byte}.
- R7: During a write data term, the lanes carrying write data are driven for every data cycle. For a byte write on the 16-bit bus, only the lane picked by A0 is driven. A byte write takes its data from req_wdata_i[7:0]. A 16-bit write sends bits 15:8 to the odd byte.
- R8: An internal-target read never changes rdata_o.
- R9: e_n_o is low only in the data term. For an internal-target access with e_inhibit_i set, it stays high throughout.
- R10: With mode_i other than 2'b01, p0..p2 and their enables equal gpio_out_i and gpio_oe_i. ale_o stays low, e_n_o stays high and no read data is captured. Requests still complete with done_o on the same timing.
- R11: With clkout_en_i high, aux_o toggles on every clock edge. Otherwise aux_o equals gpio_aux_i.
- R12: A 16-bit access on the 8-bit bus runs two complete beats: A0 = 0 with the low byte, then A0 = 1 with the high byte. done_o comes only after the second beat. A read returns {second byte, first byte}.
- R13: A request presented while busy_o is high is ignored.
- R14: After reset the block is idle: ALE low, E high, rw_o high, bhe_n_o high, done_o low and rdata_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Processor mode: 01 expansion, other values single-chip |
| clkout_en_i | input | 1 | Selects the free-running clock on aux_o |
| e_inhibit_i | input | 1 | Keeps E high for internal-target accesses |
| bus_byte_i | input | 1 | Bus width: 0 = 16-bit, 1 = 8-bit |
| req_valid_i | input | 1 | Request pulse, accepted when idle |
| req_addr_i | input | 24 | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_internal_i | input | 1 | Target is internal memory |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| gpio_out_i | input | 24 | General I/O output values for p2:p1:p0 |
| gpio_oe_i | input | 24 | General I/O enables for p2:p1:p0 |
| gpio_aux_i | input | 1 | General I/O value for aux_o |
| p0_o | output | 8 | Address-only port value |
| p0_oe_o | output | 8 | Address-only port enables |
| p1_o | output | 8 | Port 1 value (address / odd data) |
| p1_oe_o | output | 8 | Port 1 enables |
| p1_i | input | 8 | Port 1 pin input |
| p2_o | output | 8 | Port 2 value (address / even or all data) |
| p2_oe_o | output | 8 | Port 2 enables |
| p2_i | input | 8 | Port 2 pin input |
| rw_o | output | 1 | Read (high) / write (low) |
| bhe_n_o | output | 1 | Active-low byte-high enable |
| ale_o | output | 1 | Address-latch enable |
| e_n_o | output | 1 | Active-low data-term enable |
| aux_o | output | 1 | Clock output or general I/O |

## Verification
The bench walks every lane and direction combination on both bus widths. A design that swapped the odd and even lanes, or dropped the address from p1 on the 8-bit bus, shows the wrong byte on a pin in the data term. Internal reads are run with and without the inhibit. A design that captured pin data there changes rdata_o, and one that ignored the inhibit pulls E low. A 16-bit access on the 8-bit bus checks that done_o waits for the second beat and that the bytes land in order; a single-beat design completes early. Requests are also pulsed mid-cycle and in single-chip mode, where a leaky mux shows bus activity on the pins.

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl #(
  parameter int LANE_W   = 8,
  parameter int DATA_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                clkout_en_i,
  input  logic                e_inhibit_i,
  input  logic                bus_byte_i,
  input  logic                req_valid_i,
  input  logic [3*LANE_W-1:0] req_addr_i,
  input  logic                req_write_i,
  input  logic                req_wide_i,
  input  logic                req_internal_i,
  input  logic [2*LANE_W-1:0] req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*LANE_W-1:0] rdata_o,
  input  logic [3*LANE_W-1:0] gpio_out_i,
  input  logic [3*LANE_W-1:0] gpio_oe_i,
  input  logic                gpio_aux_i,
  output logic [LANE_W-1:0]   p0_o,
  output logic [LANE_W-1:0]   p0_oe_o,
  output logic [LANE_W-1:0]   p1_o,
  output logic [LANE_W-1:0]   p1_oe_o,
  input  logic [LANE_W-1:0]   p1_i,
  output logic [LANE_W-1:0]   p2_o,
  output logic [LANE_W-1:0]   p2_oe_o,
  input  logic [LANE_W-1:0]   p2_i,
  output logic                rw_o,
  output logic                bhe_n_o,
  output logic                ale_o,
  output logic                e_n_o,
  output logic                aux_o
);

  localparam int AW = 3 * LANE_W;
  localparam int DW = 2 * LANE_W;
  localparam int CW = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_CYC - 1);
  localparam logic [LANE_W-1:0] ONES = '1;
  localparam logic [LANE_W-1:0] ZERO = '0;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_HOLD, ST_DATA} phase_t;

  phase_t            state;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     r_addr;
  logic [DW-1:0]     r_wdata;
  logic [LANE_W-1:0] r_lo;
  logic              r_wr, r_wide, r_int, r_b8, r_split, r_beat2, r_clk;

  logic              expand, active, in_data, a0, odd_used, even_used, cap_en;
  logic [AW-1:0]     cur_addr;
  logic [LANE_W-1:0] b1_val, b1_oe, b2_val, b2_oe;

  assign expand    = (mode_i == 2'b01);
  assign active    = (state != ST_IDLE);
  assign in_data   = (state == ST_DATA);
  assign a0        = r_wide ? r_beat2 : r_addr[0];
  assign cur_addr  = {r_addr[AW-1:1], a0};
  assign odd_used  = r_wide | a0;
  assign even_used = r_wide | ~a0;
  assign cap_en    = expand & ~r_wr & ~r_int;

  assign busy_o  = active;
  assign ale_o   = expand & (state == ST_ADDR);
  assign e_n_o   = ~(expand & in_data & ~(r_int & e_inhibit_i));
  assign rw_o    = ~(expand & active & r_wr);
  assign bhe_n_o = ~(expand & active & (a0 | (r_wide & ~r_b8)));
  assign aux_o   = clkout_en_i ? r_clk : gpio_aux_i;

  always_comb begin
    b1_val = cur_addr[2*LANE_W-1:LANE_W];
    b1_oe  = ONES;
    b2_val = cur_addr[AW-1:2*LANE_W];
    b2_oe  = ONES;
    if (in_data) begin
      if (!r_b8) begin
        b1_val = r_wide ? r_wdata[DW-1:LANE_W] : r_wdata[LANE_W-1:0];
        b1_oe  = (r_wr & odd_used) ? ONES : ZERO;
        b2_val = r_wdata[LANE_W-1:0];
        b2_oe  = (r_wr & even_used) ? ONES : ZERO;
      end else begin
        b2_val = (r_split & r_beat2) ? r_wdata[DW-1:LANE_W] : r_wdata[LANE_W-1:0];
        b2_oe  = r_wr ? ONES : ZERO;
      end
    end
  end

  always_comb begin
    if (expand) begin
      p0_o    = cur_addr[LANE_W-1:0];
      p0_oe_o = ONES;
      p1_o    = b1_val;
      p1_oe_o = b1_oe;
      p2_o    = b2_val;
      p2_oe_o = b2_oe;
    end else begin
      p0_o    = gpio_out_i[LANE_W-1:0];
      p0_oe_o = gpio_oe_i[LANE_W-1:0];
      p1_o    = gpio_out_i[2*LANE_W-1:LANE_W];
      p1_oe_o = gpio_oe_i[2*LANE_W-1:LANE_W];
      p2_o    = gpio_out_i[AW-1:2*LANE_W];
      p2_oe_o = gpio_oe_i[AW-1:2*LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_clk <= 1'b0;
    else        r_clk <= ~r_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_lo    <= '0;
      r_wr    <= 1'b0;
      r_wide  <= 1'b0;
      r_int   <= 1'b0;
      r_b8    <= 1'b0;
      r_split <= 1'b0;
      r_beat2 <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid_i) begin
          r_addr  <= req_addr_i;
          r_wdata <= req_wdata_i;
          r_wr    <= req_write_i;
          r_wide  <= req_wide_i;
          r_int   <= req_internal_i;
          r_b8    <= bus_byte_i;
          r_split <= req_wide_i & bus_byte_i;
          r_beat2 <= 1'b0;
          state   <= ST_ADDR;
        end
        ST_ADDR: state <= ST_HOLD;
        ST_HOLD: begin
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_DATA: if (cnt == LAST) begin
          if (cap_en) begin
            if (r_split) begin
              if (!r_beat2) r_lo <= p2_i;
              else          rdata_o <= {p2_i, r_lo};
            end else if (r_b8) begin
              rdata_o <= {ZERO, p2_i};
            end else if (r_wide) begin
              rdata_o <= {p1_i, p2_i};
            end else begin
              rdata_o <= {ZERO, a0 ? p1_i : p2_i};
            end
          end
          if (r_split && !r_beat2) begin
            r_beat2 <= 1'b1;
            state   <= ST_ADDR;
          end else begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xbus_mux_ctrl_chk.sv
module xbus_mux_ctrl_chk #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [2*LANE_W-1:0] rdata_o,
  input logic [LANE_W-1:0] p0_o,
  input logic [LANE_W-1:0] p2_oe_o,
  input logic              rw_o,
  input logic              ale_o,
  input logic              e_n_o
);

  assert_ale_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_no_e_in_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> e_n_o);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && $fell(ale_o)) |-> $stable(p0_o));

  assert_read_lanes_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_n_o && rw_o) |-> (p2_oe_o == '0));

  assert_rw_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> rw_o);

  assert_rdata_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> done_o);

  assert_single_chip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b01) |-> (!ale_o && e_n_o));

endmodule

bind xbus_mux_ctrl xbus_mux_ctrl_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
  .rdata_o(rdata_o), .p0_o(p0_o), .p2_oe_o(p2_oe_o), .rw_o(rw_o),
  .ale_o(ale_o), .e_n_o(e_n_o)
);

// File: tb/xbus_mux_ctrl_tb.sv
module xbus_mux_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic clkout_en_i = 1'b0, e_inhibit_i = 1'b0, bus_byte_i = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_wide_i = 1'b0, req_internal_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [23:0] gpio_out_i = 24'hC0FFEE, gpio_oe_i = 24'h0F0FF0;
  logic gpio_aux_i = 1'b1;
  logic [7:0] p1_i = 8'hA5, p2_i = 8'h3C;
  logic busy_o, done_o, rw_o, bhe_n_o, ale_o, e_n_o, aux_o;
  logic [15:0] rdata_o;
  logic [7:0] p0_o, p0_oe_o, p1_o, p1_oe_o, p2_o, p2_oe_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xbus_mux_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clkout_en_i(clkout_en_i),
    .e_inhibit_i(e_inhibit_i), .bus_byte_i(bus_byte_i), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .req_wide_i(req_wide_i),
    .req_internal_i(req_internal_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .gpio_out_i(gpio_out_i), .gpio_oe_i(gpio_oe_i),
    .gpio_aux_i(gpio_aux_i), .p0_o(p0_o), .p0_oe_o(p0_oe_o), .p1_o(p1_o),
    .p1_oe_o(p1_oe_o), .p1_i(p1_i), .p2_o(p2_o), .p2_oe_o(p2_oe_o), .p2_i(p2_i),
    .rw_o(rw_o), .bhe_n_o(bhe_n_o), .ale_o(ale_o), .e_n_o(e_n_o), .aux_o(aux_o)
  );

  typedef struct packed {
    logic        b8, wr, wide, intl, inh;
    logic [23:0] addr;
    logic [15:0] wd;
    logic        bhe_n, e_n, p1oe;
    logic [7:0]  p1;
    logic        p2oe;
    logic [7:0]  p2;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 24'h123450, 16'hBEEF, 1'b0,1'b0,1'b1,8'hBE,1'b1,8'hEF, 16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 24'h56A0F2, 16'h0000, 1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 16'hA53C},
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 24'h000101, 16'h0000, 1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 16'h00A5},
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 24'h000200, 16'h0077, 1'b1,1'b0,1'b0,8'h00,1'b1,8'h77, 16'h00A5},
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 24'h000301, 16'h0055, 1'b0,1'b0,1'b1,8'h55,1'b0,8'h00, 16'h00A5},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 24'h000010, 16'h0000, 1'b1,1'b1,1'b0,8'h00,1'b0,8'h00, 16'h00A5},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 24'h000012, 16'h0000, 1'b1,1'b0,1'b0,8'h00,1'b0,8'h00, 16'h00A5},
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 24'h000020, 16'h0011, 1'b1,1'b1,1'b0,8'h00,1'b1,8'h11, 16'h00A5},
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 24'h784003, 16'h0000, 1'b0,1'b0,1'b1,8'h40,1'b0,8'h00, 16'h003C},
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 24'h784004, 16'h0099, 1'b1,1'b0,1'b1,8'h40,1'b1,8'h99, 16'h003C},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 24'h000300, 16'h0000, 1'b1,1'b0,1'b0,8'h00,1'b0,8'h00, 16'h003C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic b8, input logic wr, input logic wide, input logic intl,
                       input logic inh, input logic [23:0] addr, input logic [15:0] wd);
    @(negedge clk);
    bus_byte_i = b8; req_write_i = wr; req_wide_i = wide; req_internal_i = intl;
    e_inhibit_i = inh; req_addr_i = addr; req_wdata_i = wd; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 ale", ale_o, 0);
    chk("R14 e_n", e_n_o, 1);
    chk("R14 rw", rw_o, 1);
    chk("R14 bhe_n", bhe_n_o, 1);
    chk("R14 done", done_o, 0);
    chk("R14 busy", busy_o, 0);
    chk("R14 rdata", rdata_o, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      issue(v.b8, v.wr, v.wide, v.intl, v.inh, v.addr, v.wd);
      // address term (R1, R2, R4, R5)
      chk("R1 ale addr term", ale_o, 1);
      chk("R9 e_n addr term", e_n_o, 1);
      chk("R1 busy", busy_o, 1);
      chk("R4 rw", rw_o, !v.wr);
      chk("R5 bhe_n", bhe_n_o, v.bhe_n);
      chk("R2 p0 addr", {p0_oe_o, p0_o}, {8'hFF, v.addr[7:0]});
      chk("R2 p1 addr", {p1_oe_o, p1_o}, {8'hFF, v.addr[15:8]});
      chk("R2 p2 addr", {p2_oe_o, p2_o}, {8'hFF, v.addr[23:16]});
      @(negedge clk);
      chk("R1 ale hold term", ale_o, 0);
      chk("R1 p0 held", p0_o, v.addr[7:0]);
      chk("R9 e_n hold term", e_n_o, 1);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R9 e_n data term", e_n_o, v.e_n);
        chk("R4 rw data", rw_o, !v.wr);
        chk(v.b8 ? "R3 p1 oe" : "R7 p1 oe", p1_oe_o, v.p1oe ? 8'hFF : 8'h00);
        if (v.p1oe) chk(v.b8 ? "R3 p1 value" : "R2 p1 odd data", p1_o, v.p1);
        chk(v.wr ? "R7 p2 oe" : "R6 p2 oe", p2_oe_o, v.p2oe ? 8'hFF : 8'h00);
        if (v.p2oe) chk("R7 p2 data", p2_o, v.p2);
        chk("R1 no early done", done_o, 0);
      end
      @(negedge clk);
      chk("R1 done", done_o, 1);
      chk("R1 busy clear", busy_o, 0);
      chk(v.intl ? "R8 rdata" : "R6 rdata", rdata_o, v.rd);
      chk("R9 e_n idle", e_n_o, 1);
      @(negedge clk);
      chk("R1 done one cycle", done_o, 0);
    end

    // R12 16-bit read on 8-bit bus: two beats
    issue(1, 0, 1, 0, 0, 24'h9A0010, 16'h0);
    chk("R12 beat1 A0", p0_o, 8'h10);
    chk("R12 beat1 bhe_n", bhe_n_o, 1);
    repeat (2) @(negedge clk);
    chk("R12 beat1 lanes off", p2_oe_o, 8'h00);
    repeat (2) @(negedge clk);
    p2_i = 8'h81;
    chk("R12 beat2 ale", ale_o, 1);
    chk("R12 beat2 A0", p0_o, 8'h11);
    chk("R12 beat2 bhe_n", bhe_n_o, 0);
    chk("R12 no done after beat1", done_o, 0);
    chk("R12 busy", busy_o, 1);
    repeat (4) @(negedge clk);
    chk("R12 done", done_o, 1);
    chk("R12 rdata", rdata_o, 16'h813C);
    p2_i = 8'h3C;

    // R12 16-bit write on 8-bit bus
    issue(1, 1, 1, 0, 0, 24'h9A0020, 16'h1234);
    repeat (2) @(negedge clk);
    chk("R12 write beat1", {p2_oe_o, p2_o}, {8'hFF, 8'h34});
    @(negedge clk);
    chk("R12 write beat1 held", {p2_oe_o, p2_o}, {8'hFF, 8'h34});
    repeat (3) @(negedge clk);
    chk("R12 write beat2", {p2_oe_o, p2_o}, {8'hFF, 8'h12});
    chk("R3 p1 addr in data", p1_o, 8'h00);
    repeat (2) @(negedge clk);
    chk("R12 write done", done_o, 1);

    // R13 request during busy is ignored
    issue(0, 0, 0, 0, 0, 24'h000201, 16'h0);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_wide_i = 1'b1; req_addr_i = 24'hFFFFFE;
    @(negedge clk);
    req_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 first done", done_o, 1);
    chk("R13 first rdata", rdata_o, 16'h00A5);
    @(negedge clk);
    chk("R13 no second cycle busy", busy_o, 0);
    chk("R13 no second cycle ale", ale_o, 0);
    chk("R13 no second done", done_o, 0);

    // R10 single-chip mode
    mode_i = 2'b00;
    @(negedge clk);
    chk("R10 p0 gpio", {p0_oe_o, p0_o}, {gpio_oe_i[7:0], gpio_out_i[7:0]});
    chk("R10 p1 gpio", {p1_oe_o, p1_o}, {gpio_oe_i[15:8], gpio_out_i[15:8]});
    chk("R10 p2 gpio", {p2_oe_o, p2_o}, {gpio_oe_i[23:16], gpio_out_i[23:16]});
    issue(0, 0, 0, 0, 0, 24'h000300, 16'h0);
    chk("R10 ale idle", ale_o, 0);
    chk("R10 rw idle", rw_o, 1);
    chk("R10 p1 gpio busy", p1_o, gpio_out_i[15:8]);
    repeat (2) @(negedge clk);
    chk("R10 e_n idle", e_n_o, 1);
    chk("R10 p2 gpio busy", p2_oe_o, gpio_oe_i[23:16]);
    repeat (2) @(negedge clk);
    chk("R10 done", done_o, 1);
    chk("R10 no capture", rdata_o, 16'h00A5);
    mode_i = 2'b10;
    issue(0, 1, 0, 0, 0, 24'h000300, 16'h0042);
    chk("R10 mode 10 ale", ale_o, 0);
    repeat (5) @(negedge clk);
    mode_i = 2'b01;

    // R11 clock output
    clkout_en_i = 1'b0; gpio_aux_i = 1'b1;
    @(negedge clk);
    chk("R11 aux gpio 1", aux_o, 1);
    gpio_aux_i = 1'b0;
    #1 chk("R11 aux gpio 0", aux_o, 0);
    clkout_en_i = 1'b1;
    @(negedge clk);
    begin
      logic prev;
      prev = aux_o;
      @(negedge clk);
      chk("R11 aux toggles", aux_o, !prev);
      @(negedge clk);
      chk("R11 aux toggles back", aux_o, prev);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule